// File: doc/BRIEF.md
# Waveform Block Stream Generator

The generator produces a packetized test stream by replaying samples held in an internal waveform memory. Software fills the memory through a write port, programs a replay window (first and last address), the packet length, the idle gap between packets, the sync period in blocks and a 64-bit starting sequence number. It then sets the enable bit. Packets come out either right away or at the next rising edge of the PPS input.

Each packet is a run of consecutive valid cycles. The first cycle carries a start flag and the last carries an end flag. The 64-bit sequence number stays constant for the whole packet. A sync flag marks the first packet of every sync period. The read address walks through the window, wraps from the last address back to the first, and continues across packet boundaries. When enable is cleared, the packet in progress completes and the stream then stops. The next start reloads the sequence number, the window position and the sync period.

Top module: `wbg_stream_gen`

## Requirements
- R1: After reset, the registers read: control 0, packet length 256, sync period 781250, gap 80, first address 0, last address 255, and both start-sequence words 0. No valid output appears.
- R2: Registers are selected by the word index `reg_addr` (byte offset / 4) and read back zero-extended on `reg_rdata`. Index 0 is control (bit 0 enable, bit 1 wait-for-PPS), 1 is packet length, 2 is sync period in blocks, 3 is gap in cycles, 4 is first address, 5 is last address, 6 is start sequence bits 31:0 and 7 is start sequence bits 63:32.
- R3: Sample n of the stream carries the memory word at address A(n). A(0) is the first address. A(n+1) is the first address when A(n) equals the last address, and otherwise A(n)+1 modulo the memory depth. The walk continues across packets.
- R4: `out_bsn` is loaded from the start-sequence words at each start, is constant within a packet, and increases by one per packet, with carry across bit 31.
- R5: A packet is exactly L consecutive valid cycles, where L is the packet length, and a length of 0 acts as 1. `out_sop` is set on the first of these cycles and `out_eop` on the last.
- R6: `out_sync` is set only together with `out_sop`, on the first packet after a start and on every P-th packet after it, where P is the sync period and a period of 0 acts as 1.
- R7: Exactly G idle cycles separate an end of packet from the next start of packet, where G is the gap. A gap of 0 gives back-to-back packets.
- R8: With enable set and wait-for-PPS clear, the first `out_sop` appears on the second rising clock edge after the edge that samples the control write.
- R9: With both control bits set, no output appears until `pps` is seen high after being low. The first `out_sop` follows on the next clock edge.
- R10: Clearing enable lets the current packet finish all its samples, and no further packet begins. A later start reloads the sequence number, the first address and the sync count.
- R11: A waveform write stores `wave_wdata` at `wave_addr`, and the stored word is replayed by every later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| wave_wr | input | 1 | Waveform memory write strobe |
| wave_addr | input | AW | Waveform memory write address |
| wave_wdata | input | DW | Waveform memory write data |
| pps | input | 1 | Pulse-per-second input |
| out_valid | output | 1 | Sample valid |
| out_sop | output | 1 | First sample of a packet |
| out_eop | output | 1 | Last sample of a packet |
| out_sync | output | 1 | Packet opens a sync period |
| out_data | output | DW | Sample data |
| out_bsn | output | 64 | Packet sequence number |

## Verification
On every cycle, the assertions check the framing relations at the output. Start, end and sync flags only appear with valid, and sync only appears with start. A packet never breaks off before its end flag, and the sequence number holds steady inside a packet. The replayed data, the wrap of the window, the packet length, the gap, the sync period, the sequence-number carry and the reload after a restart depend on programmed values and history. Those are shown by the bench's reference model and its scenarios: immediate start, PPS-aligned start, stop and restart, a write into the window while it plays, and the zero-length, zero-gap and zero-period corners.

// File: rtl/wbg_stream_gen.sv
module wbg_stream_gen #(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int SPP_W = 16,
  parameter int BPS_W = 20,
  parameter int GAP_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          wave_wr,
  input  logic [AW-1:0] wave_addr,
  input  logic [DW-1:0] wave_wdata,
  input  logic          pps,
  output logic          out_valid,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_sync,
  output logic [DW-1:0] out_data,
  output logic [63:0]   out_bsn
);

  localparam int DEPTH = 1 << AW;
  localparam logic [SPP_W-1:0] SPP_RST = SPP_W'(256);
  localparam logic [BPS_W-1:0] BPS_RST = BPS_W'(781250);
  localparam logic [GAP_W-1:0] GAP_RST = GAP_W'(80);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_PKT, S_GAP} st_t;

  logic [1:0]       ctrl;
  logic [SPP_W-1:0] spp;
  logic [BPS_W-1:0] bps;
  logic [GAP_W-1:0] gap;
  logic [AW-1:0]    lo_addr, hi_addr;
  logic [63:0]      bsn_init;

  logic [DW-1:0]    mem [DEPTH];

  st_t              st;
  logic [SPP_W-1:0] smp;
  logic [GAP_W-1:0] gcnt;
  logic [BPS_W-1:0] blk;
  logic [63:0]      bsn;
  logic [AW-1:0]    rd_addr;
  logic             pps_q;

  wire pps_rise = pps & ~pps_q;
  wire issue    = (st == S_PKT);
  wire last_smp = ({1'b0, smp} + 1'b1) >= {1'b0, spp};
  wire gap_done = ({1'b0, gcnt} + 1'b1) >= {1'b0, gap};
  wire blk_wrap = ({1'b0, blk} + 1'b1) >= {1'b0, bps};
  wire go       = (st == S_IDLE && ctrl[0] && !ctrl[1]) ||
                  (st == S_ARM && ctrl[0] && pps_rise);
  wire [AW-1:0] nxt_addr = (rd_addr == hi_addr) ? lo_addr : rd_addr + 1'b1;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(ctrl);
      3'd1:    reg_rdata = 32'(spp);
      3'd2:    reg_rdata = 32'(bps);
      3'd3:    reg_rdata = 32'(gap);
      3'd4:    reg_rdata = 32'(lo_addr);
      3'd5:    reg_rdata = 32'(hi_addr);
      3'd6:    reg_rdata = bsn_init[31:0];
      default: reg_rdata = bsn_init[63:32];
    endcase
  end

  always_ff @(posedge clk) begin
    if (wave_wr) mem[wave_addr] <= wave_wdata;
    out_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      spp      <= SPP_RST;
      bps      <= BPS_RST;
      gap      <= GAP_RST;
      lo_addr  <= '0;
      hi_addr  <= AW'(DEPTH - 1);
      bsn_init <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0:    ctrl            <= reg_wdata[1:0];
        3'd1:    spp             <= reg_wdata[SPP_W-1:0];
        3'd2:    bps             <= reg_wdata[BPS_W-1:0];
        3'd3:    gap             <= reg_wdata[GAP_W-1:0];
        3'd4:    lo_addr         <= reg_wdata[AW-1:0];
        3'd5:    hi_addr         <= reg_wdata[AW-1:0];
        3'd6:    bsn_init[31:0]  <= reg_wdata;
        default: bsn_init[63:32] <= reg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_sync  <= 1'b0;
      out_bsn   <= '0;
    end else begin
      out_valid <= issue;
      out_sop   <= issue && smp == '0;
      out_eop   <= issue && last_smp;
      out_sync  <= issue && smp == '0 && blk == '0;
      if (issue) out_bsn <= bsn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      smp     <= '0;
      gcnt    <= '0;
      blk     <= '0;
      bsn     <= '0;
      rd_addr <= '0;
      pps_q   <= 1'b0;
    end else begin
      pps_q <= pps;
      if (go) begin
        st      <= S_PKT;
        smp     <= '0;
        blk     <= '0;
        bsn     <= bsn_init;
        rd_addr <= lo_addr;
      end else begin
        case (st)
          S_IDLE: if (ctrl[0] && ctrl[1]) st <= S_ARM;
          S_ARM:  if (!ctrl[0]) st <= S_IDLE;
          S_PKT: begin
            rd_addr <= nxt_addr;
            if (last_smp) begin
              bsn  <= bsn + 64'd1;
              blk  <= blk_wrap ? '0 : blk + 1'b1;
              smp  <= '0;
              gcnt <= '0;
              if (gap != '0) st <= S_GAP;
              else if (!ctrl[0]) st <= S_IDLE;
            end else begin
              smp <= smp + 1'b1;
            end
          end
          default: begin
            if (gap_done) st <= ctrl[0] ? S_PKT : S_IDLE;
            else gcnt <= gcnt + 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/wbg_stream_gen_chk.sv
module wbg_stream_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_sop,
  input logic        out_eop,
  input logic        out_sync,
  input logic [63:0] out_bsn
);

  p_sop_in_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);

  p_eop_in_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_valid);

  p_no_break_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |=> out_valid);

  p_mid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> ($past(out_valid) && !$past(out_eop)));

  p_sync_on_sop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> out_sop);

  p_bsn_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> $stable(out_bsn));

endmodule

bind wbg_stream_gen wbg_stream_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sop(out_sop),
  .out_eop(out_eop), .out_sync(out_sync), .out_bsn(out_bsn)
);

// File: tb/wbg_stream_gen_test.sv
module wbg_stream_gen_test;
  localparam int DW = 16, AW = 8;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, wave_wr = 0, pps = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [AW-1:0] wave_addr = 0;
  logic [DW-1:0] wave_wdata = 0, out_data;
  logic out_valid, out_sop, out_eop, out_sync;
  logic [63:0] out_bsn;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wbg_stream_gen uut (.*);

  // reference model state
  int s_ctrl, s_spp, s_bps, s_gap, s_lo, s_hi;
  logic [63:0] s_init;
  logic [DW-1:0] s_mem [256];
  int mst, smp, gc, blk, addr;
  logic [63:0] bsn;
  bit ppsq;
  bit e_valid, e_sop, e_eop, e_sync;
  logic [DW-1:0] e_data;
  logic [63:0] e_bsn;

  task automatic m_start();
    mst = 2; smp = 0; blk = 0; bsn = s_init; addr = s_lo;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      s_ctrl = 0; s_spp = 256; s_bps = 781250; s_gap = 80; s_lo = 0; s_hi = 255;
      s_init = 0; mst = 0; smp = 0; gc = 0; blk = 0; addr = 0; bsn = 0; ppsq = 0;
      e_valid = 0; e_sop = 0; e_eop = 0; e_sync = 0;
    end else begin
      bit rise;
      rise = pps && !ppsq;
      ppsq = pps;
      e_valid = (mst == 2);
      e_sop = e_valid && smp == 0;
      e_eop = e_valid && (smp + 1 >= s_spp);
      e_sync = e_sop && blk == 0;
      e_data = s_mem[addr];
      if (e_valid) e_bsn = bsn;
      case (mst)
        0: if (s_ctrl[0]) begin if (s_ctrl[1]) mst = 1; else m_start(); end
        1: if (!s_ctrl[0]) mst = 0; else if (rise) m_start();
        2: begin
          addr = (addr == s_hi) ? s_lo : (addr + 1) % 256;
          if (smp + 1 >= s_spp) begin
            bsn = bsn + 1;
            blk = (blk + 1 >= s_bps) ? 0 : blk + 1;
            smp = 0; gc = 0;
            if (s_gap != 0) mst = 3;
            else if (!s_ctrl[0]) mst = 0;
          end else smp++;
        end
        default: if (gc + 1 >= s_gap) mst = s_ctrl[0] ? 2 : 0; else gc++;
      endcase
    end
    if (rst_n && reg_wr)
      case (reg_addr)
        0: s_ctrl = int'(reg_wdata[1:0]);
        1: s_spp = int'(reg_wdata[15:0]);
        2: s_bps = int'(reg_wdata[19:0]);
        3: s_gap = int'(reg_wdata[15:0]);
        4: s_lo = int'(reg_wdata[7:0]);
        5: s_hi = int'(reg_wdata[7:0]);
        6: s_init[31:0] = reg_wdata;
        default: s_init[63:32] = reg_wdata;
      endcase
    if (wave_wr) s_mem[wave_addr] = wave_wdata;
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (out_valid !== e_valid) begin errors++; $display("FAIL R5 valid act %0b exp %0b", out_valid, e_valid); end
    if (out_sop !== e_sop) begin errors++; $display("FAIL R5 sop act %0b exp %0b", out_sop, e_sop); end
    if (out_eop !== e_eop) begin errors++; $display("FAIL R5 R7 eop act %0b exp %0b", out_eop, e_eop); end
    if (out_sync !== e_sync) begin errors++; $display("FAIL R6 sync act %0b exp %0b", out_sync, e_sync); end
    if (e_valid && out_data !== e_data) begin errors++; $display("FAIL R3 R11 data act %h exp %h", out_data, e_data); end
    if (e_valid && out_bsn !== e_bsn) begin errors++; $display("FAIL R4 bsn act %h exp %h", out_bsn, e_bsn); end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act %h exp %h", req, act, exp); end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    reg_addr = 3'(a); #1;
    chk(reg_rdata === exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic cfg(input int spp, bps, gap, lo, hi);
    wr_reg(1, spp); wr_reg(2, bps); wr_reg(3, gap); wr_reg(4, lo); wr_reg(5, hi);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd_chk(0, 0, "R1 ctrl"); rd_chk(1, 256, "R1 spp"); rd_chk(2, 781250, "R1 bps");
    rd_chk(3, 80, "R1 gap"); rd_chk(4, 0, "R1 lo"); rd_chk(5, 255, "R1 hi");
    rd_chk(6, 0, "R1 bsn lo"); rd_chk(7, 0, "R1 bsn hi");
    chk(out_valid === 0, "R1 valid", 64'(out_valid), 0);
    for (int i = 0; i < 256; i++) begin
      wave_wr = 1; wave_addr = AW'(i); wave_wdata = DW'(i * 37 + 5);
      @(negedge clk);
    end
    wave_wr = 0;
    // R2 map and readback
    cfg(5, 3, 2, 10, 16);
    wr_reg(6, 32'hFFFF_FFFE); wr_reg(7, 32'h1);
    rd_chk(1, 5, "R2 spp"); rd_chk(3, 2, "R2 gap"); rd_chk(4, 10, "R2 lo");
    rd_chk(7, 1, "R2 bsn hi");
    // R8 immediate start latency
    wr_reg(0, 1);
    @(negedge clk);
    chk(out_valid === 0, "R8 early", 64'(out_valid), 0);
    @(negedge clk);
    chk(out_sop === 1, "R8 sop", 64'(out_sop), 1);
    chk(out_bsn === 64'h1_FFFF_FFFE, "R4 init", out_bsn, 64'h1_FFFF_FFFE);
    repeat (20) @(negedge clk);
    // R11 write inside the window while playing
    wave_wr = 1; wave_addr = 12; wave_wdata = 16'hBEEF;
    @(negedge clk); wave_wr = 0;
    repeat (20) @(negedge clk);
    // R10 stop mid-packet
    while (!out_sop) @(negedge clk);
    @(negedge clk);
    wr_reg(0, 0);
    repeat (20) @(negedge clk);
    chk(out_valid === 0, "R10 stopped", 64'(out_valid), 0);
    // R10 restart reloads
    wr_reg(0, 1);
    repeat (2) @(negedge clk);
    chk(out_bsn === 64'h1_FFFF_FFFE, "R10 bsn reload", out_bsn, 64'h1_FFFF_FFFE);
    chk(out_sync === 1, "R10 sync reload", 64'(out_sync), 1);
    chk(out_data === s_mem[10], "R10 addr reload", 64'(out_data), 64'(s_mem[10]));
    repeat (30) @(negedge clk);
    wr_reg(0, 0);
    repeat (20) @(negedge clk);
    // zero length, period and gap; window wrapping through the top
    cfg(0, 0, 0, 250, 3);
    wr_reg(0, 1);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      chk(out_sop && out_eop && out_sync, "R5 R6 R7 single", {61'b0, out_sop, out_eop, out_sync}, 64'h7);
      @(negedge clk);
    end
    wr_reg(0, 0);
    repeat (5) @(negedge clk);
    // R9 PPS-aligned start
    cfg(4, 2, 3, 0, 255);
    wr_reg(0, 3);
    repeat (10) @(negedge clk);
    chk(out_valid === 0, "R9 waits", 64'(out_valid), 0);
    pps = 1;
    @(negedge clk);
    pps = 0;
    chk(out_valid === 0, "R9 pre", 64'(out_valid), 0);
    @(negedge clk);
    chk(out_sop === 1, "R9 sop", 64'(out_sop), 1);
    repeat (15) @(negedge clk);
    pps = 1; @(negedge clk); pps = 0;
    repeat (25) @(negedge clk);
    wr_reg(0, 0);
    repeat (20) @(negedge clk);
    chk(out_valid === 0, "R10 final stop", 64'(out_valid), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule